// File: doc/BRIEF.md
# Source Selection and Divider Setting Solver

This block chooses a clock source and two divider settings for a clock tree that can only divide. A request holds a target output rate together with up to four candidate source rates, and each candidate has its own present flag. For every candidate that is present and has a nonzero rate, the block works out the integer ratio needed and splits it between a pre-divider and a post-divider. It then computes the rate that those settings give. The candidate with the fastest result that does not exceed the target becomes the selection.

Only one source, index 3, feeds the pre-divider. For that source a large ratio is spread across both dividers in fixed bands. Every other source uses the post-divider alone.

The caller places the target and the candidates on the inputs and pulses `start`. The block captures all of its inputs at that edge and runs for a few hundred cycles on one shared iterative divider. It then pulses `done` with the selection, the two field codes and the achieved rate, or it raises `err` when nothing fits. The results stay on the outputs until the next accepted start. Writing the codes into a control register and generating the clock are left to the surrounding logic.

Top module: `divsel_solver`

## Requirements
- R1: A request whose target rate is zero finishes with `err` high and does not try any candidate.
- R2: When the target is above a candidate's rate, that candidate uses its own rate as the target. A target above every source therefore selects the fastest present source, with both codes zero.
- R3: The ratio is the ceiling of the source rate divided by the clamped target. A source other than index 3, or index 3 with a ratio of 4 or less, uses a pre-divide of 1 and a post-divide of min(ratio, 4).
- R4: For source 3 with a ratio above 4, the split depends on the ratio. Below 32 the pre-divide is the ratio and the post-divide is 1. From 32 to 63 the post-divide is 2 and the pre-divide is ceil(ratio/2). From 64 to 95 the post-divide is 3 and the pre-divide is ceil(ratio/3). Above that the post-divide is 4 and the pre-divide is ceil(ratio/4).
- R5: The pre-divide value never exceeds 32. A candidate whose rate then comes out above the target does not qualify.
- R6: `pre_code` is the pre-divide value minus one and sits in 5 bits. `post_code` is the post-divide value minus one and sits in 2 bits. `out_rate` is floor(floor(source / pre-divide) / post-divide).
- R7: Candidates are examined from index 0 upward. An absent candidate, or one with a zero rate, is skipped. A candidate takes over the selection only when its achieved rate is at most the target and strictly above the best found so far, so on a tie the lowest index wins.
- R8: When no candidate qualifies, `err` is high and `sel_idx`, `pre_code`, `post_code` and `out_rate` are all zero.
- R9: `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle. The result outputs change only in a `done` cycle.
- R10: `start` is accepted only while `busy` is low. A `start` pulse during a run is ignored, and the run completes on the inputs captured when it began.
- R11: After reset, `busy`, `done` and `err` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a request when idle |
| req_rate | input | RATE_W | Target output rate |
| src_rate | input | NUM_SRC*RATE_W | Candidate rates; candidate i occupies bits [i*RATE_W +: RATE_W] |
| src_present | input | NUM_SRC | Bit i marks candidate i as available |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No valid selection for the last request |
| sel_idx | output | $clog2(NUM_SRC) | Chosen candidate index |
| pre_code | output | $clog2(PRE_MAX) | Pre-divide value minus one |
| post_code | output | 2 | Post-divide value minus one |
| out_rate | output | RATE_W | Rate given by the chosen settings |

## Verification
The hardest cases to reach are the banded split and the pre-divide saturation. Both apply only when source 3 actually wins, and ordinary stimulus with several live sources hides them. The stimulus therefore leaves source 3 alone or clearly fastest, then picks targets that put the ratio on each band edge (4/5, 31/32, 63/64, 95/96) and well past 128. Past 128 the saturated pre-divide produces a rate above the target and forces an error. A second `start` is also driven into the middle of a running request, and the bench confirms that exactly one result comes back and that it belongs to the first request.

// File: rtl/divsel_pkg.sv
// Package: shared constants and the solver state type.
// Assumes: post-divider spans 1..4, so its code is 2 bits.
package divsel_pkg;
    localparam int POST_MAX = 4;
    localparam int POST_W   = 2;
    localparam int POST_VW  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RATIO,
        ST_SPLIT,
        ST_PRE,
        ST_POST,
        ST_NEXT,
        ST_FINISH
    } solve_st_e;
endpackage

// File: rtl/divsel_divider.sv
// Module: divsel_divider
// Restoring unsigned divider, one quotient bit per cycle. A go pulse
// loads the operands; done pulses once, W cycles later, with quot/rem
// valid and held until the next go.
// Assumes: divisor is nonzero whenever go is raised.
module divsel_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     acc_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     dvd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [W:0]       trial;
    logic             fits;

    // Trial subtraction of the shifted partial remainder.
    always_comb begin
        trial = {acc_q, quo_q[W-1]};
        fits  = (trial >= {1'b0, dvs_q});
    end

    // Iteration register: load on go, shift one bit per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            dvd_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                acc_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                dvd_q <= dividend;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (fits) begin
                    acc_q <= W'(trial - {1'b0, dvs_q});
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    acc_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quot = quo_q;
    assign rem  = acc_q;

    // R6
    div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (({{W{1'b0}}, quot} * {{W{1'b0}}, dvs_q}) + {{W{1'b0}}, rem}
                  == {{W{1'b0}}, dvd_q}) && (rem < dvs_q));
endmodule

// File: rtl/divsel_split.sv
// Module: divsel_split
// Splits an overall divide ratio between pre- and post-divider.
// Only the source feeding the pre-divider (use_pre) splits; it does so
// in bands of PRE_MAX when the ratio exceeds the post-divider range.
// Assumes: ratio >= 1; pure combinational.
module divsel_split
    import divsel_pkg::*;
#(
    parameter int RATIO_W = 32,
    parameter int PRE_MAX = 32,
    parameter int PRE_VW  = 6
) (
    input  logic [RATIO_W-1:0] ratio,
    input  logic               use_pre,
    output logic [PRE_VW-1:0]  pre_val,
    output logic [POST_VW-1:0] post_val
);
    localparam int BAND_W = $clog2(3 * PRE_MAX + 3);

    logic [RATIO_W-1:0] half_up;
    logic [RATIO_W-1:0] quarter_up;
    logic [BAND_W-1:0]  third_in;
    logic [BAND_W-1:0]  third_up;

    // Ceiling quotients for the three upper bands.
    always_comb begin
        half_up    = (ratio >> 1) + {{(RATIO_W-1){1'b0}}, ratio[0]};
        quarter_up = (ratio >> 2) + {{(RATIO_W-1){1'b0}}, |ratio[1:0]};
        third_in   = ratio[BAND_W-1:0];
        third_up   = (third_in + BAND_W'(2)) / BAND_W'(3);
    end

    // Band selection and saturation of the pre-divide value.
    always_comb begin
        pre_val  = PRE_VW'(1);
        post_val = (ratio >= RATIO_W'(POST_MAX)) ? POST_VW'(POST_MAX)
                                                 : ratio[POST_VW-1:0];
        if (use_pre && (ratio > RATIO_W'(POST_MAX))) begin
            if (ratio < RATIO_W'(PRE_MAX)) begin
                pre_val  = ratio[PRE_VW-1:0];
                post_val = POST_VW'(1);
            end else if (ratio < RATIO_W'(2 * PRE_MAX)) begin
                pre_val  = half_up[PRE_VW-1:0];
                post_val = POST_VW'(2);
            end else if (ratio < RATIO_W'(3 * PRE_MAX)) begin
                pre_val  = third_up[PRE_VW-1:0];
                post_val = POST_VW'(3);
            end else begin
                pre_val  = (quarter_up > RATIO_W'(PRE_MAX)) ? PRE_VW'(PRE_MAX)
                                                            : quarter_up[PRE_VW-1:0];
                post_val = POST_VW'(POST_MAX);
            end
        end
    end
endmodule

// File: rtl/divsel_solver.sv
// Module: divsel_solver (top)
// Scans the candidate sources in index order, computes ratio, split and
// achieved rate for each through one shared iterative divider, and keeps
// the fastest result not above the target. Inputs are captured on an
// accepted start; results are held until the next accepted start.
// Assumes: PRE_SRC < NUM_SRC; PRE_MAX is a power of two.
module divsel_solver
    import divsel_pkg::*;
#(
    parameter int RATE_W  = 32,
    parameter int NUM_SRC = 4,
    parameter int PRE_SRC = 3,
    parameter int PRE_MAX = 32,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int PRE_W  = $clog2(PRE_MAX)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [RATE_W-1:0]          req_rate,
    input  logic [NUM_SRC*RATE_W-1:0]  src_rate,
    input  logic [NUM_SRC-1:0]         src_present,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [IDX_W-1:0]           sel_idx,
    output logic [PRE_W-1:0]           pre_code,
    output logic [POST_W-1:0]          post_code,
    output logic [RATE_W-1:0]          out_rate
);
    localparam int PRE_VW = $clog2(PRE_MAX + 1);

    solve_st_e           st_q;
    logic [RATE_W-1:0]   src_arr [NUM_SRC];
    logic [RATE_W-1:0]   src_q   [NUM_SRC];
    logic [NUM_SRC-1:0]  pres_q;
    logic [RATE_W-1:0]   req_q;
    logic [IDX_W-1:0]    idx_q;
    logic [RATE_W-1:0]   ratio_q;
    logic [PRE_VW-1:0]   pre_q;
    logic [POST_VW-1:0]  post_q;
    logic                best_ok_q;
    logic [RATE_W-1:0]   best_rate_q;
    logic [IDX_W-1:0]    best_idx_q;
    logic [PRE_W-1:0]    best_pre_q;
    logic [POST_W-1:0]   best_post_q;
    logic                div_go_q;
    logic [RATE_W-1:0]   div_a_q;
    logic [RATE_W-1:0]   div_b_q;
    logic                div_done;
    logic [RATE_W-1:0]   div_quot;
    logic [RATE_W-1:0]   div_rem;
    logic [RATE_W-1:0]   cur_src;
    logic [RATE_W-1:0]   clamp_rate;
    logic                use_pre;
    logic [PRE_VW-1:0]   split_pre;
    logic [POST_VW-1:0]  split_post;
    logic [PRE_VW-1:0]   pre_m1;
    logic [POST_VW-1:0]  post_m1;
    logic                better;

    // Unpack the flat candidate bus, one slice per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign src_arr[g] = src_rate[g*RATE_W +: RATE_W];
    end

    // Current-candidate operands and the acceptance test.
    always_comb begin
        cur_src    = src_q[idx_q];
        clamp_rate = (req_q > cur_src) ? cur_src : req_q;
        use_pre    = (idx_q == IDX_W'(PRE_SRC));
        pre_m1     = pre_q - PRE_VW'(1);
        post_m1    = post_q - POST_VW'(1);
        better     = (div_quot <= req_q) && (div_quot > best_rate_q);
    end

    divsel_split #(
        .RATIO_W (RATE_W),
        .PRE_MAX (PRE_MAX),
        .PRE_VW  (PRE_VW)
    ) u_split (
        .ratio    (ratio_q),
        .use_pre  (use_pre),
        .pre_val  (split_pre),
        .post_val (split_post)
    );

    divsel_divider #(
        .W (RATE_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go_q),
        .dividend (div_a_q),
        .divisor  (div_b_q),
        .done     (div_done),
        .quot     (div_quot),
        .rem      (div_rem)
    );

    // Sequencer: capture, per-candidate three divisions, selection, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pres_q      <= '0;
            req_q       <= '0;
            idx_q       <= '0;
            ratio_q     <= RATE_W'(1);
            pre_q       <= PRE_VW'(1);
            post_q      <= POST_VW'(1);
            best_ok_q   <= 1'b0;
            best_rate_q <= '0;
            best_idx_q  <= '0;
            best_pre_q  <= '0;
            best_post_q <= '0;
            div_go_q    <= 1'b0;
            div_a_q     <= '0;
            div_b_q     <= RATE_W'(1);
            done        <= 1'b0;
            err         <= 1'b0;
            sel_idx     <= '0;
            pre_code    <= '0;
            post_code   <= '0;
            out_rate    <= '0;
            for (int k = 0; k < NUM_SRC; k++) src_q[k] <= '0;
        end else begin
            done     <= 1'b0;
            div_go_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q       <= req_rate;
                        pres_q      <= src_present;
                        for (int k = 0; k < NUM_SRC; k++) src_q[k] <= src_arr[k];
                        idx_q       <= '0;
                        best_ok_q   <= 1'b0;
                        best_rate_q <= '0;
                        best_idx_q  <= '0;
                        best_pre_q  <= '0;
                        best_post_q <= '0;
                        st_q        <= (req_rate == '0) ? ST_FINISH : ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (pres_q[idx_q] && (cur_src != '0)) begin
                        div_go_q <= 1'b1;
                        div_a_q  <= cur_src;
                        div_b_q  <= clamp_rate;
                        st_q     <= ST_RATIO;
                    end else begin
                        st_q     <= ST_NEXT;
                    end
                end
                ST_RATIO: begin
                    if (div_done) begin
                        ratio_q <= div_quot + {{(RATE_W-1){1'b0}}, |div_rem};
                        st_q    <= ST_SPLIT;
                    end
                end
                ST_SPLIT: begin
                    pre_q    <= split_pre;
                    post_q   <= split_post;
                    div_go_q <= 1'b1;
                    div_a_q  <= cur_src;
                    div_b_q  <= {{(RATE_W-PRE_VW){1'b0}}, split_pre};
                    st_q     <= ST_PRE;
                end
                ST_PRE: begin
                    if (div_done) begin
                        div_go_q <= 1'b1;
                        div_a_q  <= div_quot;
                        div_b_q  <= {{(RATE_W-POST_VW){1'b0}}, post_q};
                        st_q     <= ST_POST;
                    end
                end
                ST_POST: begin
                    if (div_done) begin
                        if (better) begin
                            best_ok_q   <= 1'b1;
                            best_rate_q <= div_quot;
                            best_idx_q  <= idx_q;
                            best_pre_q  <= pre_m1[PRE_W-1:0];
                            best_post_q <= post_m1[POST_W-1:0];
                        end
                        st_q <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (idx_q == IDX_W'(NUM_SRC - 1)) begin
                        st_q  <= ST_FINISH;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_CHECK;
                    end
                end
                ST_FINISH: begin
                    done      <= 1'b1;
                    err       <= !best_ok_q;
                    sel_idx   <= best_ok_q ? best_idx_q  : '0;
                    pre_code  <= best_ok_q ? best_pre_q  : '0;
                    post_code <= best_ok_q ? best_post_q : '0;
                    out_rate  <= best_ok_q ? best_rate_q : '0;
                    st_q      <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q != ST_IDLE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(out_rate) && $stable(sel_idx) && $stable(err)
                   && $stable(pre_code) && $stable(post_code)));
    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (out_rate == '0) && (sel_idx == '0) && (pre_code == '0) && (post_code == '0));
    // R7
    under_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (out_rate <= req_q) && (out_rate != '0));
    // R10
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(req_q) && $stable(pres_q));
    // R5
    split_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SPLIT) |-> (split_pre >= PRE_VW'(1)) && (split_pre <= PRE_VW'(PRE_MAX))
                               && (split_post >= POST_VW'(1)) && (split_post <= POST_VW'(POST_MAX)));
    // R3
    no_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SPLIT) && !use_pre) |-> (split_pre == PRE_VW'(1)));
endmodule

// File: tb/divsel_solver_tb.sv
module divsel_solver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int NS = 4;

    typedef struct {
        logic       err;
        logic [1:0] sel;
        logic [4:0] pre;
        logic [1:0] post;
        logic [31:0] rate;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  req_rate = '0;
    logic [NS*W-1:0] src_rate = '0;
    logic [NS-1:0] src_present = '0;
    logic          busy, done, err;
    logic [1:0]    sel_idx;
    logic [4:0]    pre_code;
    logic [1:0]    post_code;
    logic [W-1:0]  out_rate;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    logic done_prev = 1'b0;
    exp_t exp_q[$];
    exp_t last_exp;

    divsel_solver u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
        .src_rate(src_rate), .src_present(src_present), .busy(busy),
        .done(done), .err(err), .sel_idx(sel_idx), .pre_code(pre_code),
        .post_code(post_code), .out_rate(out_rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected result from the requirement text (R1..R8).
    function automatic exp_t model(input logic [31:0] rq, input logic [127:0] srcs,
                                   input logic [3:0] pres, input string tag);
        exp_t e;
        longint unsigned s, r, ratio, pre, post, ach, best;
        e.err = 1'b1; e.sel = '0; e.pre = '0; e.post = '0; e.rate = '0; e.tag = tag;
        best = 0;
        if (rq != 0) begin
            for (int i = 0; i < 4; i++) begin
                s = longint'(srcs[i*32 +: 32]);
                if (!pres[i] || s == 0) continue;
                r = (longint'(rq) > s) ? s : longint'(rq);
                ratio = (s + r - 1) / r;
                pre = 1;
                post = (ratio > 4) ? 4 : ratio;
                if (i == 3 && ratio > 4) begin
                    if (ratio < 32)      begin pre = ratio;           post = 1; end
                    else if (ratio < 64) begin pre = (ratio + 1) / 2; post = 2; end
                    else if (ratio < 96) begin pre = (ratio + 2) / 3; post = 3; end
                    else                 begin pre = (ratio + 3) / 4; post = 4; end
                end
                if (pre > 32) pre = 32;
                ach = (s / pre) / post;
                if (ach <= longint'(rq) && ach > best) begin
                    best = ach;
                    e.err = 1'b0; e.sel = 2'(i); e.pre = 5'(pre - 1);
                    e.post = 2'(post - 1); e.rate = 32'(ach);
                end
            end
        end
        return e;
    endfunction

    task automatic check_out(input exp_t e);
        n_checks++;
        if (err !== e.err || sel_idx !== e.sel || pre_code !== e.pre ||
            post_code !== e.post || out_rate !== e.rate) begin
            n_fail++;
            $display("FAIL %s: got err=%0d sel=%0d pre=%0d post=%0d rate=%0d exp err=%0d sel=%0d pre=%0d post=%0d rate=%0d",
                     e.tag, err, sel_idx, pre_code, post_code, out_rate,
                     e.err, e.sel, e.pre, e.post, e.rate);
        end
    endtask

    // Monitor: pops one expected item per done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (done_prev) begin
                    n_checks++; n_fail++;
                    $display("FAIL R9: done high two cycles, got 1 expected 0");
                end
                if (busy) begin
                    n_checks++; n_fail++;
                    $display("FAIL R9: busy during done, got 1 expected 0");
                end
                if (exp_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R10: unexpected done, got 1 expected 0");
                end else begin
                    last_exp = exp_q.pop_front();
                    check_out(last_exp);
                end
            end
            done_prev = done;
        end
    end

    // Driver: pushes the expected item, pulses start, waits for the result.
    task automatic run_op(input logic [31:0] rq, input logic [31:0] s0, input logic [31:0] s1,
                          input logic [31:0] s2, input logic [31:0] s3,
                          input logic [3:0] pres, input string tag);
        logic [127:0] v;
        v = {s3, s2, s1, s0};
        exp_q.push_back(model(rq, v, pres, tag));
        @(negedge clk);
        req_rate = rq; src_rate = v; src_present = pres; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        n_checks++;
        if (busy !== 0 || done !== 0 || err !== 0 || sel_idx !== 0 || pre_code !== 0 ||
            post_code !== 0 || out_rate !== 0) begin
            n_fail++;
            $display("FAIL R11: got busy=%0d done=%0d err=%0d rate=%0d expected all zero",
                     busy, done, err, out_rate);
        end

        run_op(32'd0,    32'd100, 32'd200, 32'd300, 32'd400, 4'hF, "R1 zero target");
        run_op(32'd50,   32'd100, 32'd200, 32'd300, 32'd400, 4'h0, "R8 all absent");
        run_op(32'd1000, 32'd500, 32'd0,   32'd0,   32'd0,   4'h1, "R2 clamp single");
        run_op(32'd9000, 32'd500, 32'd700, 32'd0,   32'd650, 4'hF, "R2 clamp fastest");
        run_op(32'd30,   32'd0,   32'd100, 32'd0,   32'd0,   4'h2, "R3 ratio four");
        run_op(32'd10,   32'd0,   32'd100, 32'd0,   32'd0,   4'h2, "R3 post saturates R8");
        run_op(32'd240,  32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R3 src3 ratio four");
        run_op(32'd192,  32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 ratio five");
        run_op(32'd96,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 band one");
        run_op(32'd31,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 ratio 31");
        run_op(32'd30,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 ratio 32");
        run_op(32'd24,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 band two");
        run_op(32'd16,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 near 63");
        run_op(32'd15,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 ratio 64");
        run_op(32'd14,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 band three R6");
        run_op(32'd10,   32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 ratio 96");
        run_op(32'd8,    32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R4 band four");
        run_op(32'd5,    32'd0,   32'd0,   32'd0,   32'd960, 4'h8, "R5 pre saturates R8");
        run_op(32'd800,  32'd800, 32'd0,   32'd800, 32'd0,   4'h5, "R7 tie lowest");
        run_op(32'd280,  32'd100, 32'd300, 32'd250, 32'd0,   4'h7, "R7 best choice");
        run_op(32'd280,  32'd100, 32'd300, 32'd250, 32'd0,   4'h5, "R7 absent skipped");
        run_op(32'd280,  32'd100, 32'd0,   32'd250, 32'd0,   4'h7, "R7 zero rate skipped");

        // R10: a second start mid-run is ignored.
        begin
            logic [127:0] v;
            v = {32'd960, 32'd0, 32'd0, 32'd0};
            exp_q.push_back(model(32'd24, v, 4'h8, "R10 first request kept"));
            @(negedge clk);
            req_rate = 32'd24; src_rate = v; src_present = 4'h8; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            req_rate = 32'd7; src_rate = {4{32'd50}}; src_present = 4'hF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (exp_q.size() == 0);
            repeat (600) @(negedge clk);
        end

        // R9: results held across an idle stretch.
        n_checks++;
        if (err !== last_exp.err || out_rate !== last_exp.rate || sel_idx !== last_exp.sel ||
            pre_code !== last_exp.pre || post_code !== last_exp.post) begin
            n_fail++;
            $display("FAIL R9 hold: got rate=%0d err=%0d expected rate=%0d err=%0d",
                     out_rate, err, last_exp.rate, last_exp.err);
        end

        for (int t = 0; t < 30; t++) begin
            run_op($urandom_range(2000000, 1), $urandom_range(50000000, 0),
                   $urandom_range(50000000, 0), $urandom_range(50000000, 0),
                   $urandom_range(50000000, 1), 4'($urandom_range(15, 0)), "R6 random mix");
        end

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule